// File: doc/BRIEF.md
# Host Processor Shared-Memory Bridge

This block lets a synchronous 32-bit host processor reach a memory system that it shares with several internal clients. When the host starts an access, the block raises a memory request to a small fixed-priority arbiter. Three internal clients share that arbiter, and the host always ranks last among them. The host sees no ready until the arbiter grants it the memory, so the number of wait states it sees depends on how busy the other clients are. Once the host holds the grant, the block opens its address and data paths with a transceiver-enable output. Each beat then goes to either the shared SRAM port or the control-register port, as the address decode input selects.

A transfer can be a single beat or a burst. Ready pulses once for each completed beat. The host can stall any beat with its wait input, and it marks the final beat with a last-beat input. The memory grant is released right after that final beat. For hosts that cannot produce a wait signal, a configuration input adds one idle cycle after the first beat of a burst. The word address steps up by one for each completed beat.

Top module: `hostmem_bridge`

## Requirements
- R1: While reset is high, and in the first cycle after it, `host_rdy`, `xcvr_en` and `host_gnt` are low.
- R2: Client index 0 has the highest priority, and exactly one requesting client is granted while the host does not hold the memory. The host is granted only in a cycle in which no client requests. While the host holds the grant, every bit of `client_gnt` stays low.
- R3: After a `host_start` pulse in idle, `host_rdy` stays low until the grant arrives. With client requests held for the first B cycles, counting the start cycle as cycle 0, the first beat can complete in cycle max(1,B)+1.
- R4: `xcvr_en` is high from the cycle after the host grant until the final beat completes, and low otherwise.
- R5: While the transceivers are enabled, each cycle with `host_wait` low completes exactly one beat and shows `host_rdy` high for that cycle only. No ready appears outside such cycles.
- R6: A cycle with `host_wait` high completes no beat and leaves the word address unchanged.
- R7: The beat that completes with `host_last` high ends the access. In the next cycle `host_gnt`, `xcvr_en` and `host_rdy` are low, and a waiting client is granted.
- R8: With `cfg_burst_wait` high, exactly one cycle with no ready follows the first beat of a burst. No such cycle follows later beats.
- R9: `host_regsel` = 1 at start routes every beat of the access to the register port (`reg_en` high, `sram_en` low). `host_regsel` = 0 routes them to the SRAM port. An enable is high only in a cycle with ready.
- R10: The first beat uses `host_addr`, and each completed beat adds one, wrapping modulo 2^ADDR_W. The register address is the low REG_AW bits. Writes (`host_wr` = 1) drive `host_wdata` and a write strobe. Reads return the selected port's read data on `host_rdata` in the ready cycle.
- R11: A `host_start` pulse while an access is in progress is ignored, and its address does not disturb the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| client_req | input | N_CLI | Requests of the higher-priority memory clients |
| client_gnt | output | N_CLI | Grants to those clients, index 0 highest |
| host_start | input | 1 | One-cycle pulse that starts a host access |
| host_addr | input | ADDR_W | Start word address, taken with `host_start` |
| host_wr | input | 1 | 1 = write access, taken with `host_start` |
| host_regsel | input | 1 | 1 = register space, 0 = shared SRAM, taken with `host_start` |
| host_wdata | input | DATA_W | Write data of the current beat |
| host_wait | input | 1 | Host-inserted wait; holds the current beat |
| host_last | input | 1 | Marks the current beat as the final one |
| cfg_burst_wait | input | 1 | Adds one idle cycle after the first burst beat |
| host_rdy | output | 1 | Beat completed this cycle |
| host_rdata | output | DATA_W | Read data, valid with `host_rdy` |
| host_gnt | output | 1 | Memory granted to the host |
| xcvr_en | output | 1 | Host address and data path enable |
| sram_en | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write strobe qualifier |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data (combinational) |
| reg_en | output | 1 | Register port access strobe |
| reg_we | output | 1 | Register port write qualifier |
| reg_addr | output | REG_AW | Register word address |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data (combinational) |

## Verification
The bench runs single-beat and four-beat accesses, both reads and writes, to both the SRAM and the register targets. A read target and a write target with different data models separate a routing fault from an address fault. Each cycle is compared against a ready pattern worked out from the stimulus. Client requests are held for several cycles to separate correct priority from a stall of the wrong length. A host wait is placed at different beats to separate "holds the beat" from "skips it". The burst-wait option is run on a single beat, on a burst, and together with a later wait, so that a gap after every beat or a gap on single beats is caught. A mid-burst client request and a stray start pulse test the grant lock and R11. A burst that starts near the top of the address range tests the address wrap.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

    // Host-side controller states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_GAP  = 2'd3
    } hmb_state_e;

    // Attributes fixed for the whole access.
    typedef struct packed {
        logic wr;
        logic regsel;
    } hmb_kind_t;

    // Beat events produced by the controller each cycle.
    typedef struct packed {
        logic load;
        logic beat;
        logic release_bus;
    } hmb_evt_t;

    function automatic logic is_busy(input hmb_state_e st);
        return (st == ST_XFER) || (st == ST_GAP);
    endfunction

endpackage

// File: rtl/hmb_arbiter.sv
module hmb_arbiter #(
    parameter int N_CLI = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CLI-1:0] cli_req,
    output logic [N_CLI-1:0] cli_gnt,
    input  logic             host_req,
    input  logic             host_release,
    output logic             host_gnt
);
    logic lock_q;
    logic taken;

    // Fixed priority: lowest index wins; the host only takes an idle bus.
    always_comb begin
        cli_gnt = '0;
        taken   = 1'b0;
        for (int i = 0; i < N_CLI; i++) begin
            if (!lock_q && !taken && cli_req[i]) begin
                cli_gnt[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

    assign host_gnt = lock_q | (host_req & ~(|cli_req));

    // The host keeps the memory from grant until its last beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (host_release) begin
            lock_q <= 1'b0;
        end else if (host_gnt) begin
            lock_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hmb_ctrl.sv
module hmb_ctrl
    import hmb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     gnt,
    input  logic     hwait,
    input  logic     hlast,
    input  logic     cfg_gap,
    output logic     mem_req,
    output logic     xcvr_en,
    output hmb_evt_t evt
);
    hmb_state_e state_q, state_d;
    logic       first_q;

    always_comb begin
        state_d          = state_q;
        evt              = '0;
        evt.load         = (state_q == ST_IDLE) && start;
        evt.beat         = (state_q == ST_XFER) && !hwait;
        evt.release_bus  = evt.beat && hlast;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_REQ;
            ST_REQ:  if (gnt)   state_d = ST_XFER;
            ST_XFER: begin
                if (evt.beat) begin
                    if (hlast)                state_d = ST_IDLE;
                    else if (first_q && cfg_gap) state_d = ST_GAP;
                end
            end
            ST_GAP:  state_d = ST_XFER;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (evt.load)      first_q <= 1'b1;
            else if (evt.beat) first_q <= 1'b0;
        end
    end

    assign mem_req = (state_q == ST_REQ);
    assign xcvr_en = is_busy(state_q);

endmodule

// File: rtl/hmb_datapath.sv
module hmb_datapath
    import hmb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int REG_AW = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  hmb_evt_t          evt,
    input  logic [ADDR_W-1:0] start_addr,
    input  hmb_kind_t         start_kind,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sram_en,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              reg_en,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_q;
    hmb_kind_t         kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            kind_q <= '0;
        end else if (evt.load) begin
            addr_q <= start_addr;
            kind_q <= start_kind;
        end else if (evt.beat) begin
            addr_q <= addr_q + ADDR_STEP;
        end
    end

    assign sram_en    = evt.beat && !kind_q.regsel;
    assign reg_en     = evt.beat &&  kind_q.regsel;
    assign sram_we    = kind_q.wr;
    assign reg_we     = kind_q.wr;
    assign sram_addr  = addr_q;
    assign reg_addr   = addr_q[REG_AW-1:0];
    assign sram_wdata = host_wdata;
    assign reg_wdata  = host_wdata;
    assign host_rdata = (evt.beat && !kind_q.wr)
                      ? (kind_q.regsel ? reg_rdata : sram_rdata)
                      : '0;

endmodule

// File: rtl/hostmem_bridge.sv
module hostmem_bridge
    import hmb_pkg::*;
#(
    parameter int N_CLI  = 3,
    parameter int ADDR_W = 10,
    parameter int REG_AW = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CLI-1:0]  client_req,
    output logic [N_CLI-1:0]  client_gnt,
    input  logic              host_start,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_regsel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wait,
    input  logic              host_last,
    input  logic              cfg_burst_wait,
    output logic              host_rdy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_gnt,
    output logic              xcvr_en,
    output logic              sram_en,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              reg_en,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    hmb_evt_t  evt;
    hmb_kind_t kind_in;
    logic      mem_req;

    assign kind_in.wr     = host_wr;
    assign kind_in.regsel = host_regsel;

    hmb_arbiter #(.N_CLI(N_CLI)) u_arb (
        .clk          (clk),
        .rst          (rst),
        .cli_req      (client_req),
        .cli_gnt      (client_gnt),
        .host_req     (mem_req),
        .host_release (evt.release_bus),
        .host_gnt     (host_gnt)
    );

    hmb_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (host_start),
        .gnt     (host_gnt),
        .hwait   (host_wait),
        .hlast   (host_last),
        .cfg_gap (cfg_burst_wait),
        .mem_req (mem_req),
        .xcvr_en (xcvr_en),
        .evt     (evt)
    );

    hmb_datapath #(
        .ADDR_W (ADDR_W),
        .REG_AW (REG_AW),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .start_addr (host_addr),
        .start_kind (kind_in),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    assign host_rdy = evt.beat;

endmodule

// File: rtl/hmb_checker.sv
module hmb_checker #(
    parameter int N_CLI  = 3,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CLI-1:0]  client_req,
    input logic [N_CLI-1:0]  client_gnt,
    input logic              host_gnt,
    input logic              host_rdy,
    input logic              host_wait,
    input logic              host_last,
    input logic              xcvr_en,
    input logic              sram_en,
    input logic              reg_en,
    input logic [ADDR_W-1:0] sram_addr
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!host_rdy && !xcvr_en && !host_gnt));

    // R2
    host_rise_alone_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_gnt) |-> (client_req == '0));

    // R2
    no_client_under_host_chk: assert property (@(posedge clk) disable iff (rst)
        host_gnt |-> (client_gnt == '0));

    // R2
    client_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(client_gnt));

    // R5
    rdy_needs_path_chk: assert property (@(posedge clk) disable iff (rst)
        host_rdy |-> (xcvr_en && host_gnt));

    // R6
    wait_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        host_wait |-> !host_rdy);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xcvr_en && $past(xcvr_en) && !$past(host_rdy)) |-> $stable(sram_addr));

    // R10
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xcvr_en && $past(xcvr_en) && $past(host_rdy))
            |-> (sram_addr == $past(sram_addr) + 1'b1));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rdy && host_last) |=> (!host_gnt && !xcvr_en && !host_rdy));

    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        !(sram_en && reg_en));

    // R9
    strobe_with_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (sram_en || reg_en) == host_rdy);

endmodule

bind hostmem_bridge hmb_checker #(.N_CLI(N_CLI), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/hostmem_bridge_bench.sv
module hostmem_bridge_bench;
    localparam int NC = 3;
    localparam int AW = 10;
    localparam int RW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] client_req = '0;
    logic [NC-1:0] client_gnt;
    logic          host_start = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_wr = 1'b0;
    logic          host_regsel = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_wait = 1'b0;
    logic          host_last = 1'b0;
    logic          cfg_burst_wait = 1'b0;
    logic          host_rdy;
    logic [DW-1:0] host_rdata;
    logic          host_gnt, xcvr_en;
    logic          sram_en, sram_we, reg_en, reg_we;
    logic [AW-1:0] sram_addr;
    logic [RW-1:0] reg_addr;
    logic [DW-1:0] sram_wdata, reg_wdata, sram_rdata, reg_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [AW-1:0] addr;
        bit            rs;
        bit            wr;
        logic [DW-1:0] data;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a, input bit rs);
        return rs ? {16'h5EED, 8'h00, a[RW-1:0]} : {16'hC0DE, 6'd0, a};
    endfunction

    function automatic logic [DW-1:0] wd_model(input logic [AW-1:0] a);
        return 32'hD000_0000 | (32'(a) * 32'd3);
    endfunction

    assign sram_rdata = rd_model(sram_addr, 1'b0);
    assign reg_rdata  = rd_model(AW'(reg_addr), 1'b1);

    hostmem_bridge #(.N_CLI(NC), .ADDR_W(AW), .REG_AW(RW), .DATA_W(DW)) u_hostmem_bridge (
        .clk(clk), .rst(rst), .client_req(client_req), .client_gnt(client_gnt),
        .host_start(host_start), .host_addr(host_addr), .host_wr(host_wr),
        .host_regsel(host_regsel), .host_wdata(host_wdata), .host_wait(host_wait),
        .host_last(host_last), .cfg_burst_wait(cfg_burst_wait), .host_rdy(host_rdy),
        .host_rdata(host_rdata), .host_gnt(host_gnt), .xcvr_en(xcvr_en),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .reg_en(reg_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(1'b0, "watchdog", 32'(cycles), 32'd20000);
            finish_run();
        end
    end

    // Scoreboard monitor: pops one expected beat per ready.
    always @(negedge clk) begin
        #2;
        if (!rst && host_rdy) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5 ready with no beat pending", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                // R9 routing
                check(e.rs ? (reg_en && !sram_en) : (sram_en && !reg_en), "R9 target select",
                      {30'd0, reg_en, sram_en}, {30'd0, e.rs, !e.rs});
                // R10 address
                check(e.rs ? (reg_addr == e.addr[RW-1:0]) : (sram_addr == e.addr),
                      "R10 beat address", e.rs ? 32'(reg_addr) : 32'(sram_addr), 32'(e.addr));
                if (e.wr) begin
                    check((e.rs ? reg_we : sram_we) && ((e.rs ? reg_wdata : sram_wdata) == e.data),
                          "R10 write data", e.rs ? reg_wdata : sram_wdata, e.data);
                end else begin
                    check(host_rdata == e.data, "R10 read data", host_rdata, e.data);
                end
            end
        end
    end

    // One host access; all expectations come from the requirement text.
    task automatic run_burst(input logic [AW-1:0] a, input int n, input bit wr,
                             input bit rs, input bit bw, input int wait_at,
                             input int busy, input bit mid_cli, input bit poke);
        int  cyc, beat, first;
        bit  waited, prev_rdy, done, gap, wait_now, poked;
        bit  exp;
        string tag;
        first = ((busy > 1) ? busy : 1) + 1;   // R3
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.addr = a + AW'(i);
            e.rs   = rs;
            e.wr   = wr;
            e.data = wr ? wd_model(a + AW'(i)) : rd_model(a + AW'(i), rs);
            sb.push_back(e);
        end
        @(negedge clk);
        host_addr = a; host_wr = wr; host_regsel = rs; cfg_burst_wait = bw;
        host_start = 1'b1;
        cyc = 0; beat = 0; waited = 0; prev_rdy = 0; done = 0; poked = 0;
        while (!done && cyc < 300) begin
            if (cyc > 0) begin
                // R11: stray start with another address while busy
                host_start = (poke && beat == 1 && !poked);
                if (host_start) begin
                    host_addr = ~a;
                    poked = 1;
                end
            end
            client_req = (cyc < busy) ? 3'b100 : ((mid_cli && beat >= 1) ? 3'b001 : 3'b000);
            host_last  = (beat == n - 1);
            host_wdata = wd_model(a + AW'(beat));
            gap        = bw && beat == 1 && prev_rdy;
            wait_now   = (cyc >= first) && beat == wait_at && !waited && !gap;
            host_wait  = wait_now;
            if (wait_now) waited = 1;
            exp = (cyc >= first) && !wait_now && !gap;
            #1;
            tag = gap ? "R8 burst gap" : wait_now ? "R6 host wait" :
                  (cyc < first) ? "R3 stall until grant" : poked ? "R11 start ignored" : "R5 beat ready";
            check(host_rdy == exp, tag, 32'(host_rdy), 32'(exp));
            check(xcvr_en == (cyc >= first), "R4 transceiver enable", 32'(xcvr_en), 32'(cyc >= first));
            if (cyc < busy && cyc >= 1)
                check(!host_gnt && client_gnt == 3'b100, "R2 client before host",
                      {28'd0, host_gnt, client_gnt}, 32'h4);
            if (beat >= 1 && client_req == 3'b001)
                check(host_gnt && client_gnt == 3'b000, "R2 host lock", {28'd0, host_gnt, client_gnt}, 32'h8);
            prev_rdy = host_rdy;
            if (host_rdy) begin
                if (beat == n - 1) done = 1;
                beat++;
            end
            @(negedge clk);
            cyc++;
        end
        host_start = 0; host_last = 0; host_wait = 0;
        #1;
        // R7
        check(!host_gnt && !xcvr_en && !host_rdy, "R7 release after last",
              {29'd0, host_gnt, xcvr_en, host_rdy}, 32'd0);
        if (mid_cli)
            check(client_gnt == 3'b001, "R7 client granted after release", 32'(client_gnt), 32'h1);
        client_req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1
        check(!host_rdy && !xcvr_en && !host_gnt, "R1 reset state",
              {29'd0, host_rdy, xcvr_en, host_gnt}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!host_rdy && !xcvr_en && !host_gnt, "R1 after reset",
              {29'd0, host_rdy, xcvr_en, host_gnt}, 32'd0);
        // R2 fixed priority with the host idle
        client_req = 3'b110;
        #1 check(client_gnt == 3'b010, "R2 priority", 32'(client_gnt), 32'h2);
        client_req = 3'b101;
        #1 check(client_gnt == 3'b001, "R2 priority", 32'(client_gnt), 32'h1);
        client_req = 3'b000;

        run_burst(10'h010, 1, 0, 0, 0, -1, 0, 0, 0);   // single SRAM read
        run_burst(10'h020, 4, 1, 0, 0, -1, 0, 0, 0);   // SRAM write burst
        run_burst(10'h040, 4, 0, 0, 0, -1, 5, 0, 0);   // R3 long stall
        run_burst(10'h033, 4, 0, 1, 0,  2, 0, 0, 0);   // R6 wait, register read
        run_burst(10'h060, 4, 0, 0, 1, -1, 0, 0, 0);   // R8 gap after first beat
        run_burst(10'h070, 1, 0, 0, 1, -1, 0, 0, 0);   // R8 single beat, no gap
        run_burst(10'h080, 4, 1, 1, 1,  3, 2, 0, 0);   // R8 with late wait, register write
        run_burst(10'h090, 4, 0, 0, 0,  0, 0, 1, 1);   // R2 lock, R11 stray start
        run_burst(10'h3FE, 4, 1, 0, 0, -1, 0, 0, 0);   // R10 address wrap

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 all beats delivered", 32'(sb.size()), 32'd0);
        finish_run();
    end

endmodule